// File: doc/BRIEF.md
# Byte-Masked Synchronous SRAM with Pipelined or Flow-Through Reads

This block is a single-port synchronous memory with a 32-bit word made of four byte lanes and a parameterizable depth. Every clock cycle both reads and may write. The write controls are all active-low. A global write strobe stores the whole word. A byte-write enable, together with four per-lane strobes, stores any subset of the lanes. When neither of these selects a lane, the cycle is a plain read. The burst address sequence is produced outside the block and arrives on the address port one word per cycle.

A static mode pin selects one of two timings. In flow-through mode the address, the controls, the lane strobes and the write data all belong to one cycle, and the addressed word is visible after one clock edge. In pipelined mode the address and the two write-qualifying strobes are registered on one edge. The lane strobes and the write data follow one cycle later. On that second edge the array is written and the output register is loaded, so read data arrives after two edges. A read that overlaps a write to the same word returns the newly merged word. The data ports are plain synchronous buses with no valid/ready handshake: a new address can be issued every cycle and the block never stalls, so no back-pressure exists.

Top module: `bwsram_top`

## Requirements
- R1: With `gwr_n` low, all four lanes of the addressed word take the write data, whatever `bwe_n` and `bw_n` hold.
- R2: With `gwr_n` high and `bwe_n` low, lane i is written only when `bw_n[i]` is low. Lane i covers data bits 8*i+7 down to 8*i, so `bw_n[0]` guards bits 7:0 and `bw_n[3]` guards bits 31:24. Any subset of lanes can be written.
- R3: With `gwr_n` high, a cycle with `bwe_n` high, or with `bwe_n` low and `bw_n` equal to 4'b1111, leaves the memory unchanged.
- R4: In pipelined mode (`pipe_mode`=1), the word for an address sampled on edge k is on `rdata` after edge k+1.
- R5: In flow-through mode (`pipe_mode`=0), the word for an address sampled on edge k is on `rdata` after edge k.
- R6: In pipelined mode, the lane strobes and the write data are taken on the edge after the address edge. `bw_n` values present during the address cycle have no effect.
- R7: A read returns data that includes a write to the same word made on the same edge, and a read in the cycle after a write to that word returns the new data.
- R8: Reset (`rst_n` low) clears the output register, so `rdata` reads 0 in pipelined mode, and it cancels any write pending from before reset. The first data cycle after reset writes nothing. Memory contents are not cleared.
- R9: In pipelined mode, back-to-back writes to different addresses each land at their own address, because each address is held one cycle until its data arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through; change only during idle cycles |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Active-low global write, stores all lanes |
| bwe_n | input | 1 | Active-low enable for the per-lane strobes |
| bw_n | input | NLANE | Active-low per-lane write strobes, bit i for data bits 8*i+7:8*i |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |

## Verification
The bench sweeps every combination of the global strobe, the lane enable and the sixteen lane patterns in both modes. It keeps a byte-level model, so a decoder that swapped lanes, dropped the global override, or wrote on an all-ones lane pattern would corrupt a word that later reads back wrong. In pipelined mode the lane pattern sent with each address differs from the one sent with its data. A design that latched the strobes with the address would therefore mask the wrong lanes. A design that wrote at the current address rather than the held one would scatter back-to-back writes. Every word is read on the exact edge the mode prescribes, so an extra or missing register stage shows up as data from a neighbouring cycle. A reset issued while write controls are active checks that no stale write survives. A read of a word written one cycle earlier checks that the new data is returned.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANE_W = 8;

  // Replace the lanes of old_w selected by lane_m with the matching lanes of new_w.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  lane_m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*LANE_W +: LANE_W] = lane_m[i] ? new_w[i*LANE_W +: LANE_W]
                                        : old_w[i*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/bwsram_wdec.sv
module bwsram_wdec #(
  parameter int NLANE = 4
) (
  input  logic             gw_n,
  input  logic             be_n,
  input  logic [NLANE-1:0] lane_n,
  output logic [NLANE-1:0] lane_we
);
  always_comb begin
    if (!gw_n)      lane_we = '1;
    else if (!be_n) lane_we = ~lane_n;
    else            lane_we = '0;
  end

  // Read-cycle decode must enable no lane
  always_comb begin
    assert_read_nomask_R3: assert (!(gw_n && (be_n || (&lane_n))) || (lane_we == '0));
  end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int NLANE  = DATA_W / 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NLANE-1:0]  lane_we,
  input  logic [DATA_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  localparam int LW = DATA_W / NLANE;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLANE; i++)
      if (lane_we[i])
        store[waddr][i*LW +: LW] <= wword[i*LW +: LW];
  end

  assign rword = store[raddr];
endmodule

// File: rtl/bwsram_top.sv
module bwsram_top
  import bwsram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int NLANE  = DATA_W / 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [NLANE-1:0]  bw_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LW = DATA_W / NLANE;

  // Address-cycle registers: used as the held write address in pipelined mode
  // and as the read address in both modes.
  logic [ADDR_W-1:0] a_q;
  logic              gw_q_n, be_q_n;
  logic [DATA_W-1:0] out_q;

  logic              sel_gw_n, sel_be_n;
  logic [ADDR_W-1:0] wr_addr;
  logic [NLANE-1:0]  lane_we;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] fwd_word;

  // Pipelined: strobes from the address cycle; flow-through: live strobes.
  assign sel_gw_n = pipe_mode ? gw_q_n : gwr_n;
  assign sel_be_n = pipe_mode ? be_q_n : bwe_n;
  assign wr_addr  = pipe_mode ? a_q    : addr;

  bwsram_wdec #(.NLANE(NLANE)) u_dec (
    .gw_n   (sel_gw_n),
    .be_n   (sel_be_n),
    .lane_n (bw_n),
    .lane_we(lane_we)
  );

  bwsram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NLANE(NLANE), .ADDR_W(ADDR_W)) u_arr (
    .clk    (clk),
    .waddr  (wr_addr),
    .lane_we(lane_we),
    .wword  (wdata),
    .raddr  (a_q),
    .rword  (arr_word)
  );

  // Bypass: the pipelined read of a_q merges the write landing on a_q this edge.
  always_comb begin
    for (int i = 0; i < NLANE; i++)
      fwd_word[i*LW +: LW] = lane_we[i] ? wdata[i*LW +: LW] : arr_word[i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      gw_q_n <= 1'b1;
      be_q_n <= 1'b1;
      out_q  <= '0;
    end else begin
      a_q    <= addr;
      gw_q_n <= gwr_n;
      be_q_n <= bwe_n;
      if (pipe_mode) out_q <= fwd_word;
    end
  end

  assign rdata = pipe_mode ? out_q : arr_word;

  // A pending global write shows the full write word on the next output.
  assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !gw_q_n) |=> (!pipe_mode || rdata == $past(wdata)));

  // With no pending write, the pipelined output is the array word one edge later.
  assert_pipe_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && gw_q_n && be_q_n) |=> (!pipe_mode || rdata == $past(arr_word)));

  // Flow-through re-read of the same word in a read cycle returns the same data.
  assert_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && gwr_n && (bwe_n || (&bw_n)) && addr == a_q)
      |=> (pipe_mode || rdata == $past(rdata)));

  // Lane merge in the package must agree with the bypass lanes used here.
  always_comb begin
    if (NLANE == 4 && DATA_W == 32)
      assert_bypass_merge_R7: assert (fwd_word == lane_merge(arr_word, wdata, lane_we));
  end
endmodule

// File: tb/sim_bwsram_top.sv
module sim_bwsram_top;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          gwr_n = 1'b1;
  logic          bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0]   model [DEPTH];
  logic [AW-1:0] pa;
  logic          pg, pb;

  always #5 clk = ~clk;

  bwsram_top #(.DEPTH(DEPTH), .DATA_W(32), .NLANE(4), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .addr(addr),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [3:0] lanes(input logic g, input logic b, input logic [3:0] w);
    if (g == 1'b0) return 4'hF;
    if (b == 1'b0) return ~w;
    return 4'h0;
  endfunction

  function automatic logic [31:0] put(input logic [31:0] o, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r = o;
    if (m[0]) r[7:0]   = d[7:0];
    if (m[1]) r[15:8]  = d[15:8];
    if (m[2]) r[23:16] = d[23:16];
    if (m[3]) r[31:24] = d[31:24];
    return r;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle and checks rdata at the next negedge.
  task automatic step(input logic [AW-1:0] a, input logic g, input logic b,
                      input logic [3:0] w, input logic [31:0] d, input string tag);
    logic [31:0] exp;
    addr = a; gwr_n = g; bwe_n = b; bw_n = w; wdata = d;
    @(posedge clk);
    if (pipe_mode) begin
      model[pa] = put(model[pa], d, lanes(pg, pb, w));
      exp = model[pa];
    end else begin
      model[a] = put(model[a], d, lanes(g, b, w));
      exp = model[a];
    end
    pa = a; pg = g; pb = b;
    @(negedge clk);
    check(rdata, exp, tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pa = '0; pg = 1'b1; pb = 1'b1;
    repeat (3) @(negedge clk);
    check(rdata, 32'h0, "R8 reset output");
    rst_n = 1'b1;
    check(rdata, 32'h0, "R8 output after release");

    // flow-through: fill all words with the global strobe
    pipe_mode = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      step(AW'(k), 1'b0, 1'b1, 4'(k), 32'hC0DE_0000 + k * 32'h0011_2233, "R1 R5 fill");

    // flow-through: every strobe combination
    for (int k = 0; k < 64; k++)
      step(AW'(k), k[5] ? 1'b1 : 1'b0, k[4] ? 1'b1 : 1'b0, k[3:0],
           32'h1357_9BDF ^ (k * 32'h0103_0507), "R1 R2 R3 R5 flow sweep");
    for (int k = 0; k < DEPTH; k++)
      step(AW'(k), 1'b1, 1'b1, 4'h0, 32'hFFFF_FFFF, "R3 R5 flow readback");

    // switch to pipelined after idle
    pipe_mode = 1'b1;
    step(4'd0, 1'b1, 1'b1, 4'hF, 32'h0, "R4 mode entry");
    // strobes of step k-1 meet lane pattern sent in step k
    for (int k = 1; k <= 64; k++)
      step(AW'(k * 5), k[5] ? 1'b1 : 1'b0, k[4] ? 1'b1 : 1'b0, 4'(k - 1),
           32'h2468_ACE0 ^ (k * 32'h0701_0503), "R2 R4 R6 pipe sweep");
    step(4'd1, 1'b1, 1'b1, 4'hF, 32'h0, "R4 pipe idle");
    for (int k = 0; k < DEPTH; k++)
      step(AW'(k), 1'b1, 1'b1, 4'h0, 32'hDEAD_BEEF, "R4 R6 pipe readback");

    // back-to-back writes to distinct addresses, then read them
    step(4'd3, 1'b0, 1'b1, 4'hF, 32'h0, "R9 addr 3");
    step(4'd4, 1'b0, 1'b1, 4'h0, 32'hAAAA_0003, "R9 addr 4");
    step(4'd5, 1'b1, 1'b0, 4'h0, 32'hAAAA_0004, "R9 addr 5");
    step(4'd3, 1'b1, 1'b1, 4'h6, 32'hAAAA_0005, "R9 data 5");
    step(4'd4, 1'b1, 1'b1, 4'hF, 32'h0, "R9 read 3");
    step(4'd5, 1'b1, 1'b1, 4'hF, 32'h0, "R9 read 4");
    step(4'd0, 1'b1, 1'b1, 4'hF, 32'h0, "R9 read 5");

    // write then read same word next cycle
    step(4'd7, 1'b1, 1'b0, 4'h0, 32'h0, "R7 addr");
    step(4'd7, 1'b1, 1'b1, 4'b1010, 32'h5A5A_A5A5, "R7 write merged");
    step(4'd0, 1'b1, 1'b1, 4'hF, 32'h0, "R7 read after write");

    // reset with a write pending: it must be cancelled
    step(4'd9, 1'b0, 1'b0, 4'h0, 32'h0, "R8 arm write");
    rst_n = 1'b0;
    pa = '0; pg = 1'b1; pb = 1'b1;
    @(negedge clk);
    check(rdata, 32'h0, "R8 reset mid run");
    rst_n = 1'b1;
    step(4'd9, 1'b1, 1'b1, 4'h0, 32'hBAD0_BAD0, "R8 first cycle no write");
    step(4'd0, 1'b1, 1'b1, 4'hF, 32'h0, "R8 word 9 intact");

    // back to flow-through after idle
    pipe_mode = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      step(AW'(k), 1'b1, 1'b0, 4'hF, 32'h0BAD_0BAD, "R3 R5 final readback");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule